// File: doc/BRIEF.md
# Multi-slot in-order retirement queue

This block keeps in-flight instructions in program order inside a circular buffer of slots and retires them in that order. When an instruction is dispatched it claims a contiguous run of slots whose length is its micro-op count, limited to the buffer size and raised to at least one. It gets back a token, which is the index of the first slot of that run. Later an execution unit reports completion by presenting the token. Each cycle the block looks at the oldest entry. If that entry has completed, it retires, the head moves past all of its slots, and the walk goes on to the next entry. The walk stops at the first entry that has not completed, when the queue runs out of entries, or when the per-cycle retirement limit is reached. A limit of zero means there is no bound.

Retired identifiers appear on a bank of lanes, lane 0 holding the oldest. The lanes are driven combinationally from the stored state. Taking the retirements is implied, and they take effect at the next clock edge. A reservation uses a valid/ready handshake, and the token is returned in the same cycle as the request. The free-slot count changes by the net effect of what is reserved and what is retired in a cycle.

A small fill-state register tracks occupancy. Its states are EMPTY, PARTIAL and FULL:
- reserve-from-empty: EMPTY goes to PARTIAL, or to FULL when the whole buffer is taken.
- fill-up: PARTIAL goes to FULL.
- drain-out: PARTIAL or FULL goes to EMPTY.
- partial-release: FULL goes to PARTIAL.

Top module: `retire_queue`

## Requirements
- R1: After synchronous reset, the following hold: free_slots equals SLOTS, empty is 1, no retire lane is valid, and the first reservation receives token 0.
- R2: A reservation claims max(1, min(rsv_uops, SLOTS)) slots. A zero-micro-op request takes one slot, and a request above SLOTS takes exactly SLOTS slots.
- R3: rsv_ready is 1 exactly when free_slots is at least the normalized slot count of the current request. When rsv_valid is 1 and rsv_ready is 0, the request is dropped: the free-slot count and the allocation pointer do not change.
- R4: rsv_token equals the allocation pointer. After an accepted reservation, the pointer advances by the normalized count modulo SLOTS.
- R5: Retirement follows program order. A completed entry does not retire while any older entry has not completed. Once the older entry completes, both retire in order.
- R6: A valid completion at one clock edge makes that entry visible on the retire lanes in the following cycle, provided all older entries have completed. Valid lanes are filled from lane 0 upward in program order, and no valid lane follows an invalid one.
- R7: At most MAX_RETIRE entries retire per cycle. With MAX_RETIRE = 0 there are SLOTS lanes, and every completed entry at the head may retire in one cycle.
- R8: At each edge, free_slots becomes the old value, minus the slots accepted by a reservation, plus the slots of the entries retired.
- R9: empty is 1 exactly when free_slots equals SLOTS.
- R10: done_err is 1 when done_valid is 1 and either done_token is SLOTS or greater, or the entry at that token is already marked completed. Such a report changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rsv_valid | input | 1 | Reservation request |
| rsv_uops | input | UOP_W | Micro-op count of the request |
| rsv_id | input | ID_W | Instruction identifier to store |
| rsv_ready | output | 1 | Enough free slots for the current request |
| rsv_token | output | PTR_W | Token (first slot index) for the current request |
| done_valid | input | 1 | Completion report |
| done_token | input | PTR_W | Token of the completed entry |
| done_err | output | 1 | Completion report is out of range or duplicated |
| ret_valid | output | LANES | Lane k retires an entry this cycle |
| ret_id | output | LANES*ID_W | Identifier of each retiring entry, lane k at bits k*ID_W |
| free_slots | output | CNT_W | Number of unclaimed slots |
| empty | output | 1 | No entry is held |

## Verification
Two pairs of functions can fall in the same cycle. In the first pair, a reservation lands in the cycle in which older entries retire. This is provoked directly by reserving while a completed entry sits at the head, and it is judged by the net free-slot value after the edge. In the second pair, a completion report for one entry arrives in the same cycle as the reservation of another. This is produced throughout a long seeded random run, and each cycle the lanes, ready, token, error flag and free count are compared against a bench model that applies retirement, reservation and completion in the order the requirements define.

// File: rtl/rq_pkg.sv
package rq_pkg;

    typedef enum logic [1:0] {
        RQ_EMPTY   = 2'd0,
        RQ_PARTIAL = 2'd1,
        RQ_FULL    = 2'd2
    } rq_fill_e;

    // Slot count for a request: bounded by the buffer, never below one.
    function automatic int unsigned rq_fit(input int unsigned req, input int unsigned total);
        int unsigned c;
        c = (req > total) ? total : req;
        return (c == 0) ? 1 : c;
    endfunction

    // Circular pointer step, with step <= total.
    function automatic int unsigned rq_advance(input int unsigned ptr, input int unsigned step,
                                               input int unsigned total);
        int unsigned s;
        s = ptr + step;
        return (s >= total) ? s - total : s;
    endfunction

endpackage

// File: rtl/rq_normalize.sv
module rq_normalize
    import rq_pkg::*;
#(
    parameter int SLOTS = 12,
    parameter int UOP_W = 5,
    parameter int CNT_W = 4
)(
    input  logic [UOP_W-1:0] uops,
    output logic [CNT_W-1:0] nslots
);

    always_comb begin
        nslots = CNT_W'(rq_fit(32'(uops), SLOTS));
    end

endmodule

// File: rtl/rq_slot_store.sv
module rq_slot_store #(
    parameter int SLOTS = 12,
    parameter int ID_W  = 8,
    parameter int PTR_W = 4,
    parameter int CNT_W = 4
)(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [PTR_W-1:0]       wr_idx,
    input  logic [ID_W-1:0]        wr_id,
    input  logic [CNT_W-1:0]       wr_n,
    input  logic                   set_en,
    input  logic [PTR_W-1:0]       set_idx,
    input  logic [SLOTS-1:0]       clr,
    output logic [SLOTS*ID_W-1:0]  ids,
    output logic [SLOTS*CNT_W-1:0] nsl,
    output logic [SLOTS-1:0]       exec
);

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        logic [ID_W-1:0]  id_q;
        logic [CNT_W-1:0] n_q;
        logic             ex_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                id_q <= '0;
                n_q  <= '0;
                ex_q <= 1'b0;
            end else if (wr_en && wr_idx == PTR_W'(i)) begin
                id_q <= wr_id;
                n_q  <= wr_n;
                ex_q <= 1'b0;
            end else begin
                if (set_en && set_idx == PTR_W'(i)) ex_q <= 1'b1;
                if (clr[i])                         ex_q <= 1'b0;
            end
        end

        assign ids[i*ID_W +: ID_W]   = id_q;
        assign nsl[i*CNT_W +: CNT_W] = n_q;
        assign exec[i]               = ex_q;
    end

    // R4
    write_free_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !exec[wr_idx]);

endmodule

// File: rtl/rq_retire_walk.sv
module rq_retire_walk
    import rq_pkg::*;
#(
    parameter int SLOTS = 12,
    parameter int LANES = 4,
    parameter int ID_W  = 8,
    parameter int PTR_W = 4,
    parameter int CNT_W = 4
)(
    input  logic [PTR_W-1:0]       head,
    input  logic [CNT_W-1:0]       free,
    input  logic [SLOTS*ID_W-1:0]  ids,
    input  logic [SLOTS*CNT_W-1:0] nsl,
    input  logic [SLOTS-1:0]       exec,
    output logic [LANES-1:0]       ret_valid,
    output logic [LANES*ID_W-1:0]  ret_id,
    output logic [SLOTS-1:0]       clr,
    output logic [PTR_W-1:0]       head_nx,
    output logic [CNT_W-1:0]       freed
);

    always_comb begin
        int  p;
        int  left;
        int  n;
        int  acc;
        logic go;
        ret_valid = '0;
        ret_id    = '0;
        clr       = '0;
        p         = int'(head);
        left      = SLOTS - int'(free);
        acc       = 0;
        n         = 0;
        go        = 1'b1;
        for (int k = 0; k < LANES; k++) begin
            if (go && left > 0 && exec[p]) begin
                n                        = int'(nsl[p*CNT_W +: CNT_W]);
                ret_valid[k]             = 1'b1;
                ret_id[k*ID_W +: ID_W]   = ids[p*ID_W +: ID_W];
                clr[p]                   = 1'b1;
                left                     = left - n;
                acc                      = acc + n;
                p                        = int'(rq_advance(p, n, SLOTS));
            end else begin
                go = 1'b0;
            end
        end
        head_nx = PTR_W'(p);
        freed   = CNT_W'(acc);
    end

endmodule

// File: rtl/retire_queue.sv
module retire_queue
    import rq_pkg::*;
#(
    parameter int SLOTS      = 12,
    parameter int MAX_RETIRE = 4,
    parameter int ID_W       = 8,
    parameter int UOP_W      = 5,
    localparam int PTR_W     = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int CNT_W     = $clog2(SLOTS + 1),
    localparam int LANES     = (MAX_RETIRE == 0 || MAX_RETIRE > SLOTS) ? SLOTS : MAX_RETIRE
)(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  rsv_valid,
    input  logic [UOP_W-1:0]      rsv_uops,
    input  logic [ID_W-1:0]       rsv_id,
    output logic                  rsv_ready,
    output logic [PTR_W-1:0]      rsv_token,
    input  logic                  done_valid,
    input  logic [PTR_W-1:0]      done_token,
    output logic                  done_err,
    output logic [LANES-1:0]      ret_valid,
    output logic [LANES*ID_W-1:0] ret_id,
    output logic [CNT_W-1:0]      free_slots,
    output logic                  empty
);

    logic [PTR_W-1:0]       head_q, alloc_q, head_nx;
    logic [CNT_W-1:0]       free_q, free_d, rsv_n, freed;
    rq_fill_e               fill_q, fill_d;
    logic [SLOTS*ID_W-1:0]  ids;
    logic [SLOTS*CNT_W-1:0] nsl;
    logic [SLOTS-1:0]       exec, clr;
    logic                   rsv_fire, tok_ok, exec_hit, set_en;

    rq_normalize #(.SLOTS(SLOTS), .UOP_W(UOP_W), .CNT_W(CNT_W)) u_norm (
        .uops   (rsv_uops),
        .nslots (rsv_n)
    );

    rq_slot_store #(.SLOTS(SLOTS), .ID_W(ID_W), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (rsv_fire),
        .wr_idx  (alloc_q),
        .wr_id   (rsv_id),
        .wr_n    (rsv_n),
        .set_en  (set_en),
        .set_idx (done_token),
        .clr     (clr),
        .ids     (ids),
        .nsl     (nsl),
        .exec    (exec)
    );

    rq_retire_walk #(.SLOTS(SLOTS), .LANES(LANES), .ID_W(ID_W), .PTR_W(PTR_W),
                     .CNT_W(CNT_W)) u_walk (
        .head      (head_q),
        .free      (free_q),
        .ids       (ids),
        .nsl       (nsl),
        .exec      (exec),
        .ret_valid (ret_valid),
        .ret_id    (ret_id),
        .clr       (clr),
        .head_nx   (head_nx),
        .freed     (freed)
    );

    // Handshake and completion screening
    always_comb begin
        rsv_ready = (free_q >= rsv_n);
        rsv_token = alloc_q;
        rsv_fire  = rsv_valid && rsv_ready;
        tok_ok    = (32'(done_token) < SLOTS);
        exec_hit  = tok_ok ? exec[done_token] : 1'b0;
        done_err  = done_valid && (!tok_ok || exec_hit);
        set_en    = done_valid && !done_err;
        free_d    = free_q - (rsv_fire ? rsv_n : '0) + freed;
    end

    // Fill-state transitions
    always_comb begin
        fill_d = fill_q;
        unique case (fill_q)
            RQ_EMPTY: begin
                if (rsv_fire) fill_d = (free_d == '0) ? RQ_FULL : RQ_PARTIAL;
            end
            RQ_PARTIAL: begin
                if (free_d == CNT_W'(SLOTS)) fill_d = RQ_EMPTY;
                else if (free_d == '0)       fill_d = RQ_FULL;
            end
            RQ_FULL: begin
                if (free_d == CNT_W'(SLOTS)) fill_d = RQ_EMPTY;
                else if (free_d != '0)       fill_d = RQ_PARTIAL;
            end
            default: fill_d = RQ_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            head_q  <= '0;
            alloc_q <= '0;
            free_q  <= CNT_W'(SLOTS);
            fill_q  <= RQ_EMPTY;
        end else begin
            head_q <= head_nx;
            if (rsv_fire)
                alloc_q <= PTR_W'(rq_advance(32'(alloc_q), 32'(rsv_n), SLOTS));
            free_q <= free_d;
            fill_q <= fill_d;
        end
    end

    // Outputs
    always_comb begin
        free_slots = free_q;
        empty      = (fill_q == RQ_EMPTY);
    end

    // R8
    free_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        free_slots <= CNT_W'(SLOTS));

    // R9
    empty_matches_free_chk: assert property (@(posedge clk) disable iff (rst)
        empty |-> (free_slots == CNT_W'(SLOTS) && !ret_valid[0]));

    // R9
    full_matches_free_chk: assert property (@(posedge clk) disable iff (rst)
        (fill_q == RQ_FULL) |-> (free_slots == '0));

    // R3
    ready_has_room_chk: assert property (@(posedge clk) disable iff (rst)
        rsv_ready |-> (free_slots != '0));

    // R4
    reserve_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
        (rsv_valid && rsv_ready) |=> !empty);

    // R6
    for (genvar k = 1; k < LANES; k++) begin : g_lane_chk
        lane_order_chk: assert property (@(posedge clk) disable iff (rst)
            ret_valid[k] |-> ret_valid[k-1]);
    end

endmodule

// File: tb/tb_retire_queue.sv
module tb_retire_queue;

    localparam int CLK_PERIOD = 10;
    localparam int SLOTS      = 12;
    localparam int LIM        = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic        rsv_valid = 1'b0;
    logic [4:0]  rsv_uops = '0;
    logic [7:0]  rsv_id = '0;
    logic        rsv_ready;
    logic [3:0]  rsv_token;
    logic        done_valid = 1'b0;
    logic [3:0]  done_token = '0;
    logic        done_err;
    logic [3:0]  ret_valid;
    logic [31:0] ret_id;
    logic [3:0]  free_slots;
    logic        empty;

    logic        u_rsv_valid = 1'b0;
    logic [4:0]  u_rsv_uops = '0;
    logic [7:0]  u_rsv_id = '0;
    logic        u_rsv_ready;
    logic [3:0]  u_rsv_token;
    logic        u_done_valid = 1'b0;
    logic [3:0]  u_done_token = '0;
    logic        u_done_err;
    logic [11:0] u_ret_valid;
    logic [95:0] u_ret_id;
    logic [3:0]  u_free_slots;
    logic        u_empty;

    retire_queue dut (
        .clk(clk), .rst(rst), .rsv_valid(rsv_valid), .rsv_uops(rsv_uops), .rsv_id(rsv_id),
        .rsv_ready(rsv_ready), .rsv_token(rsv_token), .done_valid(done_valid),
        .done_token(done_token), .done_err(done_err), .ret_valid(ret_valid), .ret_id(ret_id),
        .free_slots(free_slots), .empty(empty)
    );

    retire_queue #(.MAX_RETIRE(0)) dut_u (
        .clk(clk), .rst(rst), .rsv_valid(u_rsv_valid), .rsv_uops(u_rsv_uops), .rsv_id(u_rsv_id),
        .rsv_ready(u_rsv_ready), .rsv_token(u_rsv_token), .done_valid(u_done_valid),
        .done_token(u_done_token), .done_err(u_done_err), .ret_valid(u_ret_valid),
        .ret_id(u_ret_id), .free_slots(u_free_slots), .empty(u_empty)
    );

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    int m_id[SLOTS];
    int m_n[SLOTS];
    bit m_ex[SLOTS];
    bit m_live[SLOTS];
    int m_head = 0;
    int m_alloc = 0;
    int m_free = SLOTS;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int norm(input int u);
        int c;
        c = (u > SLOTS) ? SLOTS : u;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int pick(input bit want_ex);
        int s;
        s = int'($urandom % SLOTS);
        for (int i = 0; i < SLOTS; i++) begin
            int p;
            p = (s + i) % SLOTS;
            if (m_live[p] && (m_ex[p] == want_ex)) return p;
        end
        return -1;
    endfunction

    // One cycle on the limited instance, checked against the model.
    task automatic step(input bit rv, input int uops, input int id, input bit dv, input int tok);
        int cnt, p, left, n;
        int e_pos[LIM];
        int e_id[LIM];
        bit exp_ready, exp_err;
        @(negedge clk);
        rsv_valid  = rv;
        rsv_uops   = 5'(uops);
        rsv_id     = 8'(id);
        done_valid = dv;
        done_token = 4'(tok);
        #1;
        cnt = 0; p = m_head; left = SLOTS - m_free;
        while (cnt < LIM && left > 0 && m_ex[p]) begin
            e_pos[cnt] = p; e_id[cnt] = m_id[p];
            left -= m_n[p];
            p = (p + m_n[p]) % SLOTS;
            cnt++;
        end
        for (int k = 0; k < LIM; k++) begin
            chk(ret_valid[k] == (k < cnt), "R6/R7 lane valid", ret_valid[k], (k < cnt));
            if (k < cnt) chk(ret_id[k*8 +: 8] == 8'(e_id[k]), "R6 lane id", ret_id[k*8 +: 8], e_id[k]);
        end
        n = norm(uops);
        exp_ready = (m_free >= n);
        chk(rsv_ready == exp_ready, "R3 ready", rsv_ready, exp_ready);
        if (rv) chk(rsv_token == 4'(m_alloc), "R4 token", rsv_token, m_alloc);
        exp_err = dv && ((tok >= SLOTS) || m_ex[tok % SLOTS]);
        if (dv) chk(done_err == exp_err, "R10 done_err", done_err, exp_err);
        chk(free_slots == 4'(m_free), "R8 free", free_slots, m_free);
        chk(empty == (m_free == SLOTS), "R9 empty", empty, (m_free == SLOTS));
        @(posedge clk);
        for (int k = 0; k < cnt; k++) begin
            m_ex[e_pos[k]] = 0;
            m_live[e_pos[k]] = 0;
            m_free += m_n[e_pos[k]];
        end
        m_head = p;
        if (rv && exp_ready) begin
            m_id[m_alloc] = id & 8'hff; m_n[m_alloc] = n; m_ex[m_alloc] = 0; m_live[m_alloc] = 1;
            m_alloc = (m_alloc + n) % SLOTS;
            m_free -= n;
        end
        if (dv && !exp_err) m_ex[tok] = 1;
        #1;
        rsv_valid = 1'b0;
        done_valid = 1'b0;
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog (all requirements): actual 0 expected 1");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < SLOTS; i++) begin
            m_id[i] = 0; m_n[i] = 0; m_ex[i] = 0; m_live[i] = 0;
        end
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        chk(free_slots == 4'd12, "R1 free after reset", free_slots, 12);
        chk(empty == 1'b1, "R1 empty after reset", empty, 1);
        chk(ret_valid == 4'd0, "R1 lanes idle", ret_valid, 0);
        chk(rsv_token == 4'd0, "R1 first token", rsv_token, 0);

        // R2 zero micro-ops takes one slot
        step(1, 0, 8'h11, 0, 0);
        chk(free_slots == 4'd11, "R2 zero uops", free_slots, 11);
        step(0, 0, 0, 1, 0);
        chk(ret_valid[0] && ret_id[7:0] == 8'h11, "R6 retire next cycle", ret_id[7:0], 8'h11);
        idle();
        chk(empty == 1'b1 && free_slots == 4'd12, "R9 drained", free_slots, 12);

        // R2 cap at buffer size, R3 rejection when full
        step(1, 20, 8'h22, 0, 0);
        chk(free_slots == 4'd0, "R2 capped", free_slots, 0);
        chk(empty == 1'b0, "R9 not empty", empty, 0);
        step(1, 1, 8'h33, 0, 0);
        chk(free_slots == 4'd0, "R3 dropped request", free_slots, 0);
        chk(rsv_token == 4'd1, "R3 pointer held", rsv_token, 1);
        step(0, 0, 0, 1, 1);
        idle();
        chk(free_slots == 4'd12, "R8 full release", free_slots, 12);

        // R5 order: younger completes first
        step(1, 3, 8'hA1, 0, 0);
        step(1, 2, 8'hB2, 0, 0);
        step(0, 0, 0, 1, 4);
        chk(ret_valid == 4'd0, "R5 younger waits", ret_valid, 0);
        idle();
        chk(ret_valid == 4'd0, "R5 still waits", ret_valid, 0);
        step(0, 0, 0, 1, 1);
        chk(ret_valid == 4'b0011 && ret_id[15:0] == 16'hB2A1, "R5 both in order",
            ret_id[15:0], 16'hB2A1);
        idle();

        // R10 bad and duplicate completions
        step(0, 0, 0, 1, 13);
        chk(free_slots == 4'd12, "R10 out-of-range no effect", free_slots, 12);
        step(1, 1, 8'hC3, 0, 0);
        step(0, 0, 0, 1, 6);
        step(0, 0, 0, 1, 6);
        idle();

        // R7 limit of four per cycle
        for (int i = 0; i < 6; i++) step(1, 1, 8'h40 + i, 0, 0);
        for (int t = 8; t <= 12; t++) step(0, 0, 0, 1, t % SLOTS);
        step(0, 0, 0, 1, 7);
        chk($countones(ret_valid) == 4, "R7 four lanes", $countones(ret_valid), 4);
        idle();
        chk($countones(ret_valid) == 2, "R7 remainder", $countones(ret_valid), 2);
        idle();

        // R8 reserve in the same cycle as a retirement
        step(1, 1, 8'h51, 0, 0);
        step(0, 0, 0, 1, 1);
        step(1, 2, 8'h52, 0, 0);
        chk(free_slots == 4'd10, "R8 net update", free_slots, 10);
        step(0, 0, 0, 1, 2);
        idle();

        // R7 unlimited instance
        for (int i = 0; i < SLOTS; i++) begin
            @(negedge clk);
            u_rsv_valid = 1'b1; u_rsv_uops = 5'd1; u_rsv_id = 8'(8'h80 + i);
            @(posedge clk); #1 u_rsv_valid = 1'b0;
        end
        for (int t = 1; t <= SLOTS; t++) begin
            @(negedge clk);
            u_done_valid = 1'b1; u_done_token = 4'(t % SLOTS);
            @(posedge clk); #1 u_done_valid = 1'b0;
        end
        @(negedge clk);
        chk(u_ret_valid == 12'hFFF, "R7 unlimited lanes", u_ret_valid, 12'hFFF);
        for (int k = 0; k < SLOTS; k++)
            chk(u_ret_id[k*8 +: 8] == 8'(8'h80 + k), "R7 unlimited order", u_ret_id[k*8 +: 8], 8'h80 + k);
        @(posedge clk); #1;
        chk(u_empty == 1'b1 && u_free_slots == 4'd12, "R9 unlimited drained", u_free_slots, 12);

        // Random mix
        for (int c = 0; c < 1500; c++) begin
            bit rv, dv;
            int uops, tok, r;
            rv = ($urandom % 10) < 6;
            r = int'($urandom % 10);
            uops = (r == 0) ? 13 + int'($urandom % 19) : int'($urandom % 5);
            dv = 0; tok = 0;
            r = int'($urandom % 20);
            if (r == 0) begin
                dv = 1; tok = 12 + int'($urandom % 4);
            end else if (r == 1) begin
                tok = pick(1);
                dv = (tok >= 0);
                if (tok < 0) tok = 0;
            end else if (r < 12) begin
                tok = pick(0);
                dv = (tok >= 0);
                if (tok < 0) tok = 0;
            end
            step(rv, uops, int'($urandom % 256), dv, tok);
        end

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule